// File: doc/BRIEF.md
# Gated Countdown System Timer

A single-channel down-counting event timer placed in a small register window. Two registers are visible: a control register holding a clock-enable bit, an interrupt-enable bit and a self-clearing acknowledge bit, and a tick register that loads the countdown when written and returns the remaining count when read.

The clock-enable bit gates the whole channel. While it is clear, the counter is frozen, tick writes are dropped and a control write can change nothing but the clock-enable bit itself. Software therefore first sets the clock-enable bit, then writes the interrupt controls, and then writes a tick value. That write starts the countdown. When the count reaches zero, a pending flag is set and the counter holds at zero. The interrupt line is the pending flag qualified by the interrupt-enable bit.

Top module: `cdtmr_top`

## Requirements
- R1: After reset the control register reads 0, the tick register reads 0 and `irq` is low.
- R2: A control write while clock-enable (bit 0) is clear updates only bit 0. The interrupt-enable bit (bit 1) keeps its value.
- R3: A write to the tick register (offset 0x44) while clock-enable is clear is ignored, and the counter stays frozen.
- R4: A tick write while clock-enable is set loads the counter and starts the countdown. The count then falls by one per clock, and a read of offset 0x44 returns the remaining count.
- R5: Tick values below 3 are loaded as 3, the shortest timeout the channel supports.
- R6: When the count steps from 1 to 0, the pending flag is set. The counter then stays at 0 and does not reload.
- R7: `irq` is high exactly when the pending flag is set and interrupt-enable (bit 1 of offset 0x40) is set.
- R8: Writing bit 4 of the control register as 1 while clock-enable is set clears the pending flag. Bit 4 always reads as 0.
- R9: Writing 0 to the control register stops the channel: the count freezes, interrupt-enable clears and `irq` falls.
- R10: An acknowledge (bit 4) written while clock-enable is clear has no effect, and the pending flag survives.
- R11: Offsets other than 0x40 and 0x44 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter steps once per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W (8) | Register offset for both read and write |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr` (combinational) |
| irq | output | 1 | Timer interrupt, level |

## Verification
The hardest state to reach from the ports is a pending flag that outlives a period with the channel gated off. To get there, the stimulus runs a countdown to zero, writes 0 to the control register, issues an acknowledge while gated, and then re-enables in two writes: clock first, then the interrupt. If `irq` comes back high, the acknowledge was ignored. A second case stops the channel mid-count and checks the frozen value on the exact cycle after the stopping write. On that edge the counter still took one last step.

// File: rtl/cdtmr_pkg.sv
package cdtmr_pkg;

    // Control register field positions (software decodes these)
    localparam int CLK_EN_BIT = 0;
    localparam int IRQ_EN_BIT = 1;
    localparam int ACK_BIT    = 4;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_TICKS = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic irq_en;
        logic clk_en;
    } ctrl_s;

    typedef struct packed {
        logic clk_en;
        logic irq_en;
        logic ack;
    } ctrl_wfields_s;

    function automatic ctrl_wfields_s split_ctrl(input logic b_en, input logic b_ie,
                                                 input logic b_ack);
        ctrl_wfields_s f;
        f.clk_en = b_en;
        f.irq_en = b_ie;
        f.ack    = b_ack;
        return f;
    endfunction

endpackage

// File: rtl/cdtmr_decode.sv
module cdtmr_decode
    import cdtmr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CTRL_OFS = 'h40,
    parameter int TICK_OFS = 'h44
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output reg_sel_e          sel,
    output logic              ctrl_wr,
    output logic              tick_wr
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] TICK_A = ADDR_W'(TICK_OFS);

    always_comb begin
        if (addr == CTRL_A)      sel = SEL_CTRL;
        else if (addr == TICK_A) sel = SEL_TICKS;
        else                     sel = SEL_NONE;
    end

    assign ctrl_wr = wr_en && (sel == SEL_CTRL);
    assign tick_wr = wr_en && (sel == SEL_TICKS);
endmodule

// File: rtl/cdtmr_ctrl.sv
module cdtmr_ctrl
    import cdtmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  ctrl_wfields_s wf,
    output ctrl_s         ctrl,
    output logic          ack_pulse
);
    ctrl_s ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.clk_en <= wf.clk_en;
            // interrupt-enable only moves while the clock is already on
            if (ctrl_q.clk_en) ctrl_q.irq_en <= wf.irq_en;
        end
    end

    assign ctrl      = ctrl_q;
    assign ack_pulse = ctrl_wr && ctrl_q.clk_en && wf.ack;
endmodule

// File: rtl/cdtmr_counter.sv
module cdtmr_counter #(
    parameter int DATA_W    = 32,
    parameter int MIN_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              ack,
    output logic [DATA_W-1:0] count,
    output logic              running,
    output logic              pending
);
    localparam logic [DATA_W-1:0] MIN_V = DATA_W'(MIN_TICKS);
    localparam logic [DATA_W-1:0] ONE_V = DATA_W'(1);

    logic [DATA_W-1:0] cnt_q;
    logic              run_q;
    logic              pend_q;
    logic [DATA_W-1:0] start_v;
    logic              expire;

    assign start_v = (load_val < MIN_V) ? MIN_V : load_val;
    assign expire  = clk_en && !load && run_q && (cnt_q == ONE_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (!clk_en) begin
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= start_v;
            run_q <= 1'b1;
        end else if (run_q) begin
            cnt_q <= cnt_q - ONE_V;
            if (cnt_q == ONE_V) run_q <= 1'b0;
        end
    end

    // expiry wins over a simultaneous acknowledge so no event is lost
    always_ff @(posedge clk) begin
        if (rst)         pend_q <= 1'b0;
        else if (expire) pend_q <= 1'b1;
        else if (ack)    pend_q <= 1'b0;
    end

    assign count   = cnt_q;
    assign running = run_q;
    assign pending = pend_q;
endmodule

// File: rtl/cdtmr_top.sv
module cdtmr_top
    import cdtmr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CTRL_OFS  = 'h40,
    parameter int TICK_OFS  = 'h44,
    parameter int MIN_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    reg_sel_e          sel;
    logic              ctrl_wr;
    logic              tick_wr;
    ctrl_s             ctrl;
    ctrl_wfields_s     wf;
    logic              ack_pulse;
    logic [DATA_W-1:0] count;
    logic              running;
    logic              pending;
    logic              load;

    cdtmr_decode #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS),
        .TICK_OFS(TICK_OFS)
    ) u_dec (
        .addr   (addr),
        .wr_en  (wr_en),
        .sel    (sel),
        .ctrl_wr(ctrl_wr),
        .tick_wr(tick_wr)
    );

    assign wf = split_ctrl(wdata[CLK_EN_BIT], wdata[IRQ_EN_BIT], wdata[ACK_BIT]);

    cdtmr_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .wf       (wf),
        .ctrl     (ctrl),
        .ack_pulse(ack_pulse)
    );

    assign load = tick_wr && ctrl.clk_en;

    cdtmr_counter #(
        .DATA_W   (DATA_W),
        .MIN_TICKS(MIN_TICKS)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clk_en  (ctrl.clk_en),
        .load    (load),
        .load_val(wdata),
        .ack     (ack_pulse),
        .count   (count),
        .running (running),
        .pending (pending)
    );

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                rdata[CLK_EN_BIT] = ctrl.clk_en;
                rdata[IRQ_EN_BIT] = ctrl.irq_en;
            end
            SEL_TICKS: rdata = count;
            default:   rdata = '0;
        endcase
    end

    assign irq = pending && ctrl.irq_en;
endmodule

// File: rtl/cdtmr_chk.sv
module cdtmr_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CTRL_OFS  = 'h40,
    parameter int TICK_OFS  = 'h44,
    parameter int MIN_TICKS = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              clk_en,
    input logic              irq_en,
    input logic [DATA_W-1:0] count,
    input logic              running,
    input logic              pending,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] TICK_A = ADDR_W'(TICK_OFS);
    localparam logic [DATA_W-1:0] MIN_V  = DATA_W'(MIN_TICKS);
    localparam logic [DATA_W-1:0] ONE_V  = DATA_W'(1);

    logic tick_w, ctrl_w;
    assign tick_w = wr_en && (addr == TICK_A);
    assign ctrl_w = wr_en && (addr == CTRL_A);

    assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
        (clk_en && running && count > ONE_V && !tick_w) |=> count == $past(count) - ONE_V);

    assert_floor_load_R5: assert property (@(posedge clk) disable iff (rst)
        (clk_en && tick_w) |=> count >= MIN_V);

    assert_gated_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && tick_w) |=> $stable(count));

    assert_gated_ie_R2: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && ctrl_w) |=> $stable(irq_en));

    assert_hold_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !tick_w) |=> count == '0);

    assert_pend_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> count == '0);

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !$past(clk_en)) |=> $stable(count));
endmodule

bind cdtmr_top cdtmr_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_OFS (CTRL_OFS),
    .TICK_OFS (TICK_OFS),
    .MIN_TICKS(MIN_TICKS)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .clk_en (ctrl.clk_en),
    .irq_en (ctrl.irq_en),
    .count  (count),
    .running(running),
    .pending(pending),
    .irq    (irq)
);

// File: tb/sim_cdtmr_top.sv
module sim_cdtmr_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_TICK = 8'h44;

    // {tick value, cycles to wait, expected count, expected irq}
    localparam logic [31:0] VEC [6][4] = '{
        '{32'd10,  32'd4,   32'd6, 32'd0},
        '{32'd5,   32'd5,   32'd0, 32'd1},
        '{32'd1,   32'd0,   32'd3, 32'd0},
        '{32'd0,   32'd3,   32'd0, 32'd1},
        '{32'd200, 32'd200, 32'd0, 32'd1},
        '{32'd2,   32'd2,   32'd1, 32'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [31:0] rv;

    cdtmr_top u0 (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .irq  (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog R1 actual=hang expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // table walk: enable clock, then interrupt, then load and count
        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h3);
        for (int i = 0; i < 6; i++) begin
            wr(A_CTRL, 32'h13);
            check("R8 ack before load", {31'b0, irq}, 32'h0);
            wr(A_TICK, VEC[i][0]);
            idle(int'(VEC[i][1]));
            rd(A_TICK, rv);
            check(VEC[i][0] < 3 ? "R5 floored count" : "R4 remaining count", rv, VEC[i][2]);
            check("R6 R7 irq after countdown", {31'b0, irq}, VEC[i][3]);
        end

        // directed
        do_reset();
        rd(A_CTRL, rv); check("R1 ctrl after reset", rv, 32'h0);
        rd(A_TICK, rv); check("R1 count after reset", rv, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        wr(A_TICK, 32'd20);
        idle(2);
        rd(A_TICK, rv); check("R3 gated tick write", rv, 32'h0);

        wr(A_CTRL, 32'h3);
        rd(A_CTRL, rv); check("R2 only clock enable taken", rv, 32'h1);
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, rv); check("R2 irq enable once clocked", rv, 32'h3);

        wr(A_TICK, 32'd40);
        idle(5);
        rd(A_TICK, rv); check("R4 count after 5", rv, 32'd35);

        wr(A_CTRL, 32'h0);
        rd(A_TICK, rv); check("R9 frozen at stop", rv, 32'd34);
        idle(4);
        rd(A_TICK, rv); check("R9 still frozen", rv, 32'd34);
        rd(A_CTRL, rv); check("R9 ctrl cleared", rv, 32'h0);

        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h3);
        wr(A_TICK, 32'd3);
        idle(2);
        check("R6 no irq before zero", {31'b0, irq}, 32'h0);
        idle(1);
        check("R6 irq at zero", {31'b0, irq}, 32'h1);
        idle(4);
        rd(A_TICK, rv); check("R6 holds at zero", rv, 32'h0);

        wr(A_CTRL, 32'h1);
        check("R7 masked pending", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h3);
        check("R7 unmasked pending", {31'b0, irq}, 32'h1);

        wr(A_CTRL, 32'h0);
        check("R9 irq falls on stop", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h10);
        rd(A_CTRL, rv); check("R10 gated ack leaves ctrl", rv, 32'h0);
        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h3);
        check("R10 pending survived gated ack", {31'b0, irq}, 32'h1);

        wr(A_CTRL, 32'h13);
        check("R8 ack clears", {31'b0, irq}, 32'h0);
        rd(A_CTRL, rv); check("R8 ack bit reads 0", rv, 32'h3);

        wr(8'h48, 32'hFFFF_FFFF);
        rd(8'h48, rv); check("R11 unmapped read", rv, 32'h0);
        rd(A_CTRL, rv); check("R11 ctrl untouched", rv, 32'h3);
        rd(A_TICK, rv); check("R11 count untouched", rv, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule